// File: doc/BRIEF.md
# Mixed-Width Tagged Ternary Search Array

This block is a small ternary search array that holds up to three tables of different widths in one store of 72-bit entries. Each entry has a value, a care mask and a valid flag. A 72-bit table uses single entries. A 144-bit table uses aligned pairs of entries, and a 288-bit table uses aligned groups of four. The two top bits of every entry and of every key beat form a table tag. The compare includes these bits, so a key only finds entries of its own table.

A search key arrives as a run of 72-bit beats. The first beat is flagged with `key_start` and its tag fixes the search width. Tag 00 selects the 72-bit table and tag 01 the 144-bit table; both take two beats. Tag 10 selects the 288-bit table and takes four beats. Tag 11 starts no search. Entries are loaded through a separate write port. Once the final beat is in, the block reports a hit flag and the lowest matching base index. The report comes after a fixed four-cycle latency plus a programmable extra delay of 0 to 7 cycles.

Top module: `tagged_tcam`

## Requirements
- R1: A write with `wr_en` high stores value, mask and valid at `wr_idx` from the next cycle on; an entry written with valid low never matches.
- R2: A tag-00 search takes two beats; only the first beat is compared, one entry per candidate, and the second beat's content has no effect.
- R3: A key bit whose entry mask bit is 0 matches either value; a bit whose mask bit is 1 must equal the entry value.
- R4: A tag-01 search takes two beats; beat k is compared against entry base+k, and only even bases are candidates.
- R5: A tag-10 search takes four beats; beat k is compared against entry base+k, and only bases that are multiples of 4 are candidates.
- R6: The key tag in bits [71:70] is compared like any other bit, so a key never hits an entry of another table; a start beat with tag 11 begins no search and ends any partial one.
- R7: When several bases match, `res_index` is the lowest one. On a miss `res_hit` is 0 and `res_index` is 0. Out of reset all outputs are 0.
- R8: If the final beat of a search is presented in cycle n, `res_valid` is high for exactly cycle n+4+`hlat` and `res_hit` is never high without it.
- R9: Every `hlat` value from 0 to 7 adds that many cycles to the result time; `hlat` is changed only while no result is pending.
- R10: Searches of different widths may follow each other with no idle cycle, and each one gives its own result at its own time.
- R11: A start beat arriving before the current search has all its beats discards the partial search, which produces no result.
- R12: A write in the same cycle as a compared key beat is not seen by that beat; searches afterwards see the new entry.
- R13: A beat with `key_valid` high and `key_start` low while no search is open is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 5 | Entry index to write |
| wr_value | input | 72 | Entry value, tag in [71:70] |
| wr_mask | input | 72 | Entry care mask, 1 = compare |
| wr_valid | input | 1 | Valid flag stored with the entry |
| key_valid | input | 1 | Key beat present |
| key_start | input | 1 | Beat is the first of a search |
| key_data | input | 72 | Key beat, tag in [71:70] |
| hlat | input | 3 | Extra result delay in cycles |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A base matched |
| res_index | output | 5 | Lowest matching base index |

## Verification
The bench aims at alignment. A 144-bit or 288-bit key is laid across an odd or misaligned base, where a design that ignored alignment would report a false hit. It also corrupts single later beats; a design that compared only the first beat would still hit. Duplicate entries and a masked low byte check priority and don't-care handling. The tests cover a 72-bit key carrying another table's tag, a tag-11 start, a truncated 288-bit run, stray beats and a write colliding with a compare. Each of these would show up as an extra result, a missing result or a hit that should not exist. Back-to-back mixed widths and several delay settings check that each result lands in exactly its own cycle.

// File: rtl/tagged_tcam.sv
module tagged_tcam #(
  parameter int ENTRIES  = 32,
  parameter int KW       = 72,
  parameter int BASE_LAT = 4,
  parameter int MAX_HLAT = 7,
  localparam int IW    = $clog2(ENTRIES),
  localparam int HW    = $clog2(MAX_HLAT + 1),
  localparam int DEPTH = BASE_LAT - 1 + MAX_HLAT,
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [KW-1:0] wr_value,
  input  logic [KW-1:0] wr_mask,
  input  logic          wr_valid,
  input  logic          key_valid,
  input  logic          key_start,
  input  logic [KW-1:0] key_data,
  input  logic [HW-1:0] hlat,
  output logic          res_valid,
  output logic          res_hit,
  output logic [IW-1:0] res_index
);

  logic [KW-1:0]      val [ENTRIES];
  logic [KW-1:0]      msk [ENTRIES];
  logic [ENTRIES-1:0] vld, cmp, cmp_sh, acc, nxt, fvec;
  logic               busy, fire, any;
  logic [1:0]         wtag, beat;
  logic [IW-1:0]      pidx;
  logic [DEPTH-1:0]   pv, ph;
  logic [IW-1:0]      pi [DEPTH];
  logic [TW-1:0]      tap;

  wire [1:0] ktag     = key_data[KW-1:KW-2];
  wire       start_ok = key_valid && key_start && ktag != 2'b11;
  wire       cont     = key_valid && !key_start && busy;
  wire       last     = cont && (wtag == 2'b10 ? beat == 2'd3 : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      val[wr_idx] <= wr_value;
      msk[wr_idx] <= wr_mask;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign cmp[i] = vld[i] && (((key_data ^ val[i]) & msk[i]) == '0);
  end

  assign cmp_sh = cmp >> beat;

  always_comb begin
    for (int b = 0; b < ENTRIES; b++) begin
      if (start_ok)
        nxt[b] = cmp[b] && (ktag == 2'b00 ||
                            (ktag == 2'b01 && b % 2 == 0) ||
                            (ktag == 2'b10 && b % 4 == 0));
      else if (cont && wtag != 2'b00)
        nxt[b] = acc[b] && cmp_sh[b];
      else
        nxt[b] = acc[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wtag <= 2'b00;
      beat <= 2'd0;
      acc  <= '0;
      fvec <= '0;
      fire <= 1'b0;
    end else begin
      fire <= last;
      acc  <= nxt;
      if (last) fvec <= nxt;
      if (key_valid && key_start) begin
        busy <= start_ok;
        wtag <= ktag;
        beat <= 2'd1;
      end else if (cont) begin
        beat <= beat + 2'd1;
        if (last) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    any  = |fvec;
    pidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (fvec[i]) pidx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      ph <= '0;
      for (int k = 0; k < DEPTH; k++) pi[k] <= '0;
    end else begin
      pv    <= {pv[DEPTH-2:0], fire};
      ph    <= {ph[DEPTH-2:0], fire && any};
      pi[0] <= (fire && any) ? pidx : '0;
      for (int k = 1; k < DEPTH; k++) pi[k] <= pi[k-1];
    end
  end

  assign tap       = TW'(BASE_LAT - 2) + TW'(hlat);
  assign res_valid = pv[tap];
  assign res_hit   = ph[tap];
  assign res_index = pi[tap];

endmodule

// File: rtl/tagged_tcam_chk.sv
module tagged_tcam_chk #(
  parameter int ENTRIES = 32,
  parameter int KW      = 72,
  parameter int HW      = 3,
  localparam int IW     = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IW-1:0]      wr_idx,
  input logic               wr_valid,
  input logic               key_valid,
  input logic               key_start,
  input logic [KW-1:0]      key_data,
  input logic [HW-1:0]      hlat,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IW-1:0]      res_index,
  input logic               busy,
  input logic [ENTRIES-1:0] vld
);

  assert_write_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)] == $past(wr_valid));

  assert_tag11_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_start && key_data[KW-1:KW-2] == 2'b11 |=> !busy);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_index == '0);

  assert_hit_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);

  assert_base_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && hlat == '0 |-> $past(key_valid, 4));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid || hlat != $past(hlat));

endmodule

bind tagged_tcam tagged_tcam_chk #(.ENTRIES(ENTRIES), .KW(KW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
  .key_valid(key_valid), .key_start(key_start), .key_data(key_data), .hlat(hlat),
  .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
  .busy(busy), .vld(vld)
);

// File: tb/tagged_tcam_bench.sv
`timescale 1ns/1ps
module tagged_tcam_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [71:0] wr_value = '0, wr_mask = '0;
  logic        key_valid = 1'b0, key_start = 1'b0;
  logic [71:0] key_data = '0;
  logic [2:0]  hlat = '0;
  logic        res_valid, res_hit;
  logic [4:0]  res_index;

  tagged_tcam u_tagged_tcam (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nres = 0, next = 0;
  int rcyc [64];
  logic rhit [64];
  logic [4:0] ridx [64];
  bit done = 1'b0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (res_valid && nres < 64) begin
    rcyc[nres] = cyc; rhit[nres] = res_hit; ridx[nres] = res_index; nres++;
  end

  // vector: req[19:16] tag[15:14] start[13:9] bad beat[8:6] (7 = none) hit[5] idx[4:0]
  localparam logic [19:0] VEC [15] = '{
    {4'd2, 2'b00, 5'd0,  3'd7, 1'b1, 5'd0},   // R2 plain x72 hit
    {4'd2, 2'b00, 5'd5,  3'd7, 1'b1, 5'd5},   // R2
    {4'd7, 2'b00, 5'd2,  3'd7, 1'b1, 5'd2},   // R7 entry 7 duplicates entry 2
    {4'd3, 2'b00, 5'd3,  3'd0, 1'b1, 5'd3},   // R3 flipped bit is masked off
    {4'd3, 2'b00, 5'd4,  3'd0, 1'b0, 5'd0},   // R3 flipped bit is cared
    {4'd6, 2'b00, 5'd9,  3'd7, 1'b0, 5'd0},   // R6 x144 entry, x72 tag
    {4'd4, 2'b01, 5'd10, 3'd7, 1'b1, 5'd10},  // R4
    {4'd4, 2'b01, 5'd14, 3'd7, 1'b1, 5'd14},  // R4
    {4'd4, 2'b01, 5'd11, 3'd7, 1'b0, 5'd0},   // R4 odd base
    {4'd4, 2'b01, 5'd10, 3'd1, 1'b0, 5'd0},   // R4 second beat wrong
    {4'd5, 2'b10, 5'd20, 3'd7, 1'b1, 5'd20},  // R5
    {4'd5, 2'b10, 5'd28, 3'd7, 1'b1, 5'd28},  // R5
    {4'd5, 2'b10, 5'd22, 3'd7, 1'b0, 5'd0},   // R5 misaligned base
    {4'd5, 2'b10, 5'd16, 3'd2, 1'b0, 5'd0},   // R5 third beat wrong
    {4'd6, 2'b01, 5'd16, 3'd7, 1'b0, 5'd0}    // R6 x288 entries, x144 tag
  };

  function automatic logic [69:0] pat(int i);
    return {6'(i), 64'hC3C3_5A5A_0000_0000 | 64'(i * 7 + 1)};
  endfunction

  function automatic logic [71:0] beatval(logic [1:0] tag, int start, int k, int bad);
    logic [69:0] d;
    if (tag == 2'b00 && k == 1) d = ~pat(start);
    else d = pat(start + k);
    if (k == bad) d[0] = ~d[0];
    return {tag, d};
  endfunction

  task automatic wr(int idx, logic [71:0] v, logic [71:0] m, bit ok);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_value = v; wr_mask = m; wr_valid = ok;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(logic [1:0] tag, int start, int bad, int nb, output int fin);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      key_valid = 1'b1; key_start = (k == 0);
      key_data = beatval(tag, start, k, bad);
      fin = cyc;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    key_valid = 1'b0; key_start = 1'b0;
  endtask

  task automatic expect_res(int req, int ecyc, bit eh, int ei);
    checks++;
    if (next >= nres) begin
      errors++;
      $display("FAIL R%0d no result: actual none expected cycle %0d hit %0d idx %0d", req, ecyc, eh, ei);
    end else begin
      if (rcyc[next] != ecyc || rhit[next] != eh || ridx[next] != 5'(ei)) begin
        errors++;
        $display("FAIL R%0d actual cycle %0d hit %0d idx %0d expected cycle %0d hit %0d idx %0d",
                 req, rcyc[next], rhit[next], ridx[next], ecyc, eh, ei);
      end
      next++;
    end
  endtask

  task automatic expect_none(int req);
    checks++;
    if (nres != next) begin
      errors++;
      $display("FAIL R%0d actual %0d extra results expected 0", req, nres - next);
    end
    next = nres;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: actual hung expected completion");
    finish_run();
  end

  initial begin
    int f1, f2, f3;
    repeat (4) @(negedge clk);
    // R7 outputs idle in reset
    checks++;
    if (res_valid || res_hit || res_index != 0) begin
      errors++;
      $display("FAIL R7 reset outputs actual %0b%0b%0d expected 000", res_valid, res_hit, res_index);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 32; i++) begin
      logic [1:0] t;
      t = (i < 8) ? 2'b00 : (i < 16) ? 2'b01 : 2'b10;
      wr(i, {t, (i == 7) ? pat(2) : pat(i)}, (i == 3) ? {64'hFFFF_FFFF_FFFF_FFFF, 8'h00} : '1, 1'b1);
    end

    for (int v = 0; v < 15; v++) begin
      issue(VEC[v][15:14], int'(VEC[v][13:9]), int'(VEC[v][8:6]), (VEC[v][15:14] == 2'b10) ? 4 : 2, f1);
      idle();
      repeat (8) @(negedge clk);
      expect_res(int'(VEC[v][19:16]), f1 + 4, VEC[v][5], int'(VEC[v][4:0]));
    end

    // R12 write colliding with the compared beat
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd1; wr_value = {2'b00, pat(40)}; wr_mask = '1; wr_valid = 1'b1;
    key_valid = 1'b1; key_start = 1'b1; key_data = beatval(2'b00, 40, 0, 7);
    @(negedge clk);
    wr_en = 1'b0; key_start = 1'b0; key_data = beatval(2'b00, 40, 1, 7); f1 = cyc;
    idle();
    repeat (8) @(negedge clk);
    expect_res(12, f1 + 4, 1'b0, 0);
    issue(2'b00, 40, 7, 2, f1); idle();
    repeat (8) @(negedge clk);
    expect_res(12, f1 + 4, 1'b1, 1);

    // R1 invalidated entry
    wr(0, {2'b00, pat(0)}, '1, 1'b0);
    issue(2'b00, 0, 7, 2, f1); idle();
    repeat (8) @(negedge clk);
    expect_res(1, f1 + 4, 1'b0, 0);

    // R10 back-to-back mixed widths
    issue(2'b00, 2, 7, 2, f1);
    issue(2'b01, 12, 7, 2, f2);
    issue(2'b10, 24, 7, 4, f3);
    idle();
    repeat (8) @(negedge clk);
    expect_res(10, f1 + 4, 1'b1, 2);
    expect_res(10, f2 + 4, 1'b1, 12);
    expect_res(10, f3 + 4, 1'b1, 24);

    // R11 truncated x288 run replaced by a new start
    issue(2'b10, 20, 7, 2, f1);
    issue(2'b00, 5, 7, 2, f2);
    idle();
    repeat (10) @(negedge clk);
    expect_res(11, f2 + 4, 1'b1, 5);
    expect_none(11);

    // R13 stray beat with no open search
    @(negedge clk);
    key_valid = 1'b1; key_start = 1'b0; key_data = beatval(2'b00, 5, 0, 7);
    idle();
    repeat (10) @(negedge clk);
    expect_none(13);

    // R6 tag 11 start
    issue(2'b11, 5, 7, 2, f1); idle();
    repeat (10) @(negedge clk);
    expect_none(6);

    // R9 extra delay settings
    hlat = 3'd7;
    issue(2'b10, 20, 7, 4, f1); idle();
    repeat (14) @(negedge clk);
    expect_res(9, f1 + 11, 1'b1, 20);
    hlat = 3'd3;
    issue(2'b01, 10, 7, 2, f1); idle();
    repeat (10) @(negedge clk);
    expect_res(9, f1 + 7, 1'b1, 10);
    hlat = 3'd0;

    finish_run();
  end
endmodule